// File: doc/BRIEF.md
# Double Fault Status Tracker

This block watches the stream of instructions that a processor core retires and keeps one status bit that records whether the core is already inside a synchronous exception handler. A retired instruction that trapped outside debug mode sets the bit. The exception-return instruction clears it. Software can also change it by writing, setting or clearing bit 6 of a custom control/status register with the usual CSR instructions. When a second synchronous exception retires while the bit is still set, the block raises a one-cycle double-fault pulse.

The CSR file reads the current bit through a dedicated output. Each retired instruction is presented for one cycle with its valid, trap and debug-mode markers, its 32-bit encoding and the value it read from rs1. The block is a pure observer of that stream and has no other inputs.

Top module: `dfault_tracker`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it, nest_flag_o and double_fault_o are 0.
- R2: A retired instruction with rt_valid_i=1, rt_trap_i=1 and rt_debug_i=0 is a new synchronous exception, and nest_flag_o is 1 in the next cycle.
- R3: A trapped instruction retired with rt_debug_i=1 sets no flag and raises no pulse.
- R4: double_fault_o is 1 for exactly the one cycle after a new synchronous exception that retires while nest_flag_o is 1, unless R11 suppresses it.
- R5: Retiring the word 32'h30200073 without a new exception makes nest_flag_o 0 in the next cycle.
- R6: A CSR instruction touches the flag only when bits [6:0] are 7'h73 and bits [31:20] equal STATUS_ADDR (default 12'h7C0). Any other address or opcode has no effect.
- R7: funct3 (bits [14:12]) 001 writes the flag with rs1 bit 6. funct3 101 writes it with 0.
- R8: funct3 010 ORs rs1 bit 6 into the flag. funct3 110 leaves it unchanged.
- R9: funct3 011 clears the flag when rs1 bit 6 is 1. funct3 111 leaves it unchanged.
- R10: In one cycle, a new synchronous exception takes precedence over exception return, and exception return takes precedence over a CSR update.
- R11: At most one cycle of any PULSE_GAP+1 consecutive cycles (default 3) has double_fault_o high. A qualifying exception that would break this raises no pulse.
- R12: With rt_valid_i=0, neither the flag nor the pulse changes, whatever the other inputs carry.
- R13: funct3 000 and 100 at the status address leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rt_valid_i | input | 1 | An instruction retires this cycle |
| rt_trap_i | input | 1 | The retiring instruction trapped |
| rt_debug_i | input | 1 | The core is in debug mode |
| rt_insn_i | input | 32 | Encoding of the retiring instruction |
| rt_rs1_i | input | 32 | Value the instruction read from rs1 |
| nest_flag_o | output | 1 | Current exception-nesting status bit |
| double_fault_o | output | 1 | One-cycle double-fault pulse |

## Verification
The bench builds the block with the default status address 12'h7C0, bit position 6 and PULSE_GAP of 2. With bit 6, the immediate CSR forms cannot reach the flag, so their zero-operand behaviour is covered. A gap of 2 lets back-to-back trapping instructions show both a suppressed and a permitted second pulse within a few cycles. A long stream mixing traps, returns, debug traps and all eight funct3 codes checks the priority order against the model cycle by cycle.

// File: rtl/dft_pkg.sv
package dft_pkg;

    typedef enum logic [1:0] {
        CSR_NONE  = 2'd0,
        CSR_WRITE = 2'd1,
        CSR_SET   = 2'd2,
        CSR_CLEAR = 2'd3
    } csr_act_e;

    localparam logic [6:0]  OPC_SYSTEM = 7'h73;
    localparam logic [31:0] ERET_WORD  = 32'h30200073;

endpackage

// File: rtl/dft_csr_decode.sv
module dft_csr_decode
    import dft_pkg::*;
#(
    parameter logic [11:0] STATUS_ADDR = 12'h7C0,
    parameter int          BIT_POS     = 6,
    parameter int          XLEN        = 32
) (
    input  logic [31:0]   insn_i,
    input  logic [XLEN-1:0] rs1_i,
    output csr_act_e      act_o,
    output logic          operand_o
);
    localparam int IMM_W = 5;

    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [11:0] addr;
    logic        hit;
    logic        imm_bit;

    assign opc  = insn_i[6:0];
    assign f3   = insn_i[14:12];
    assign addr = insn_i[31:20];
    assign hit  = (opc == OPC_SYSTEM) && (addr == STATUS_ADDR) && (f3[1:0] != 2'b00);

    generate
        if (BIT_POS < IMM_W) begin : g_imm_reach
            assign imm_bit = insn_i[15 + BIT_POS];
        end else begin : g_imm_zero
            assign imm_bit = 1'b0;
        end
    endgenerate

    assign operand_o = f3[2] ? imm_bit : rs1_i[BIT_POS];

    always_comb begin
        act_o = CSR_NONE;
        if (hit) begin
            unique case (f3[1:0])
                2'b01:   act_o = CSR_WRITE;
                2'b10:   act_o = CSR_SET;
                2'b11:   act_o = CSR_CLEAR;
                default: act_o = CSR_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dft_retire_classify.sv
module dft_retire_classify
    import dft_pkg::*;
(
    input  logic        valid_i,
    input  logic        trap_i,
    input  logic        debug_i,
    input  logic [31:0] insn_i,
    output logic        new_exc_o,
    output logic        eret_o,
    output logic        csr_ok_o
);
    assign new_exc_o = valid_i & trap_i & ~debug_i;
    assign eret_o    = valid_i & (insn_i == ERET_WORD);
    assign csr_ok_o  = valid_i;
endmodule

// File: rtl/dft_pulse_gate.sv
module dft_pulse_gate #(
    parameter int PULSE_GAP = 2
) (
    input  logic                 req_i,
    input  logic [PULSE_GAP-1:0] hist_i,
    output logic                 fire_o,
    output logic [PULSE_GAP-1:0] hist_o
);
    assign fire_o = req_i & ~(|hist_i);

    generate
        if (PULSE_GAP == 1) begin : g_single
            assign hist_o = fire_o;
        end else begin : g_shift
            assign hist_o = {hist_i[PULSE_GAP-2:0], fire_o};
        end
    endgenerate
endmodule

// File: rtl/dfault_tracker.sv
module dfault_tracker
    import dft_pkg::*;
#(
    parameter logic [11:0] STATUS_ADDR = 12'h7C0,
    parameter int          BIT_POS     = 6,
    parameter int          PULSE_GAP   = 2,
    parameter int          XLEN        = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rt_valid_i,
    input  logic            rt_trap_i,
    input  logic            rt_debug_i,
    input  logic [31:0]     rt_insn_i,
    input  logic [XLEN-1:0] rt_rs1_i,
    output logic            nest_flag_o,
    output logic            double_fault_o
);
    typedef struct packed {
        logic                 flag;
        logic [PULSE_GAP-1:0] hist;
    } state_t;

    state_t   st_d, st_q;
    csr_act_e csr_act;
    logic     csr_operand;
    logic     new_exc, eret_hit, csr_ok;
    logic     fire;
    logic [PULSE_GAP-1:0] hist_next;

    dft_csr_decode #(
        .STATUS_ADDR (STATUS_ADDR),
        .BIT_POS     (BIT_POS),
        .XLEN        (XLEN)
    ) u_decode (
        .insn_i    (rt_insn_i),
        .rs1_i     (rt_rs1_i),
        .act_o     (csr_act),
        .operand_o (csr_operand)
    );

    dft_retire_classify u_classify (
        .valid_i   (rt_valid_i),
        .trap_i    (rt_trap_i),
        .debug_i   (rt_debug_i),
        .insn_i    (rt_insn_i),
        .new_exc_o (new_exc),
        .eret_o    (eret_hit),
        .csr_ok_o  (csr_ok)
    );

    dft_pulse_gate #(
        .PULSE_GAP (PULSE_GAP)
    ) u_gate (
        .req_i  (new_exc & st_q.flag),
        .hist_i (st_q.hist),
        .fire_o (fire),
        .hist_o (hist_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hist = hist_next;
        if (new_exc) begin
            st_d.flag = 1'b1;
        end else if (eret_hit) begin
            st_d.flag = 1'b0;
        end else if (csr_ok) begin
            unique case (csr_act)
                CSR_WRITE: st_d.flag = csr_operand;
                CSR_SET:   st_d.flag = st_q.flag | csr_operand;
                CSR_CLEAR: st_d.flag = st_q.flag & ~csr_operand;
                default:   st_d.flag = st_q.flag;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nest_flag_o    = st_q.flag;
    assign double_fault_o = st_q.hist[0];
endmodule

// File: rtl/dfault_tracker_checker.sv
module dfault_tracker_checker #(
    parameter int PULSE_GAP = 2
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        rt_valid_i,
    input logic        rt_trap_i,
    input logic        rt_debug_i,
    input logic [31:0] rt_insn_i,
    input logic        nest_flag_o,
    input logic        double_fault_o
);
    int   since_q;
    logic exc;

    assign exc = rt_valid_i & rt_trap_i & ~rt_debug_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q <= PULSE_GAP;
        end else if (double_fault_o) begin
            since_q <= 0;
        end else if (since_q < PULSE_GAP) begin
            since_q <= since_q + 1;
        end
    end

    assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc |=> nest_flag_o);

    assert_debug_no_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rt_valid_i && rt_trap_i && rt_debug_i) |=> !double_fault_o);

    assert_pulse_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !exc |=> !double_fault_o);

    assert_eret_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rt_valid_i && !exc && rt_insn_i == 32'h30200073) |=> !nest_flag_o);

    assert_spacing_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        double_fault_o |-> (since_q >= PULSE_GAP));

    assert_idle_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rt_valid_i |=> ($stable(nest_flag_o) && !double_fault_o));
endmodule

bind dfault_tracker dfault_tracker_checker #(
    .PULSE_GAP (PULSE_GAP)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rt_valid_i     (rt_valid_i),
    .rt_trap_i      (rt_trap_i),
    .rt_debug_i     (rt_debug_i),
    .rt_insn_i      (rt_insn_i),
    .nest_flag_o    (nest_flag_o),
    .double_fault_o (double_fault_o)
);

// File: tb/dfault_tracker_bench.sv
module dfault_tracker_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [11:0] ADDR       = 12'h7C0;
    localparam int          GAP        = 2;
    localparam logic [31:0] ERET       = 32'h30200073;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        v = 1'b0, t = 1'b0, d = 1'b0;
    logic [31:0] insn = 32'h0, rs1 = 32'h0;
    logic        flag_o, df_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    bit m_flag = 0;
    bit m_df   = 0;
    int cyc    = 0;
    int last   = -100;

    always #(CLK_PERIOD/2) clk = ~clk;

    dfault_tracker #(
        .STATUS_ADDR (ADDR),
        .BIT_POS     (6),
        .PULSE_GAP   (GAP),
        .XLEN        (32)
    ) u_dfault_tracker (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .rt_valid_i     (v),
        .rt_trap_i      (t),
        .rt_debug_i     (d),
        .rt_insn_i      (insn),
        .rt_rs1_i       (rs1),
        .nest_flag_o    (flag_o),
        .double_fault_o (df_o)
    );

    function automatic bit csr_next(bit cur, logic [31:0] w, logic [31:0] r);
        bit opnd;
        if (w[6:0] != 7'h73 || w[31:20] != ADDR) return cur;
        opnd = (w[14] == 1'b1) ? 1'b0 : r[6];
        case (w[13:12])
            2'b01: return opnd;
            2'b10: return cur | opnd;
            2'b11: return cur & ~opnd;
            default: return cur;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = 0;
            m_df   = 0;
            last   = -100;
        end else begin
            bit exc;
            bit nf;
            exc  = v && t && !d;
            m_df = exc && m_flag && (cyc - last > GAP);
            if (m_df) last = cyc;
            nf = m_flag;
            if (exc)                nf = 1;
            else if (v && insn == ERET) nf = 0;
            else if (v)             nf = csr_next(m_flag, insn, rs1);
            m_flag = nf;
        end
        cyc++;
    end

    task automatic compare(string tag);
        n_cmp++;
        if (flag_o !== m_flag) begin
            n_bad++;
            $display("FAIL %s flag actual=%0b expected=%0b", tag, flag_o, m_flag);
        end
        n_cmp++;
        if (df_o !== m_df) begin
            n_bad++;
            $display("FAIL %s pulse actual=%0b expected=%0b", tag, df_o, m_df);
        end
    endtask

    task automatic step(string tag, logic iv, logic it, logic id,
                        logic [31:0] iw, logic [31:0] ir);
        v = iv; t = it; d = id; insn = iw; rs1 = ir;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [31:0] csr(logic [2:0] f3, logic [11:0] a);
        return {a, 5'd1, f3, 5'd2, 7'h73};
    endfunction

    localparam logic [31:0] B6  = 32'h40;
    localparam logic [31:0] NOP = 32'h00000013;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, including while a trap is presented
        v = 1; t = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        v = 0; t = 0;
        @(posedge clk);
        @(negedge clk);
        compare("R1");

        step("R12", 1'b0, 1'b1, 1'b0, NOP, 0);
        step("R3",  1'b1, 1'b1, 1'b1, NOP, 0);
        step("R2",  1'b1, 1'b1, 1'b0, NOP, 0);
        step("R12", 1'b0, 1'b1, 1'b0, NOP, 0);
        step("R4",  1'b1, 1'b1, 1'b0, NOP, 0);
        step("R11", 1'b1, 1'b1, 1'b0, NOP, 0);
        step("R11", 1'b1, 1'b1, 1'b0, NOP, 0);
        step("R11", 1'b1, 1'b1, 1'b0, NOP, 0);
        step("R4",  1'b1, 1'b0, 1'b0, NOP, 0);
        step("R3",  1'b1, 1'b1, 1'b1, NOP, 0);
        step("R12", 1'b0, 1'b0, 1'b0, ERET, 0);
        step("R5",  1'b1, 1'b0, 1'b0, ERET, 0);
        step("R10", 1'b1, 1'b1, 1'b0, ERET, 0);
        step("R5",  1'b1, 1'b0, 1'b0, ERET, 0);
        // CSR operations on the status address
        step("R7",  1'b1, 1'b0, 1'b0, csr(3'b001, ADDR), B6);
        step("R7",  1'b1, 1'b0, 1'b0, csr(3'b101, ADDR), B6);
        step("R8",  1'b1, 1'b0, 1'b0, csr(3'b010, ADDR), B6);
        step("R9",  1'b1, 1'b0, 1'b0, csr(3'b011, ADDR), 32'hFFFF_FFBF);
        step("R9",  1'b1, 1'b0, 1'b0, csr(3'b011, ADDR), B6);
        step("R8",  1'b1, 1'b0, 1'b0, csr(3'b110, ADDR), 32'hFFFF_FFFF);
        step("R8",  1'b1, 1'b0, 1'b0, csr(3'b010, ADDR), 32'hFFFF_FFBF);
        step("R7",  1'b1, 1'b0, 1'b0, csr(3'b001, ADDR), B6);
        step("R9",  1'b1, 1'b0, 1'b0, csr(3'b111, ADDR), 32'hFFFF_FFFF);
        step("R13", 1'b1, 1'b0, 1'b0, csr(3'b000, ADDR), 0);
        step("R13", 1'b1, 1'b0, 1'b0, csr(3'b100, ADDR), 0);
        step("R6",  1'b1, 1'b0, 1'b0, csr(3'b001, ADDR + 12'h1), 0);
        step("R6",  1'b1, 1'b0, 1'b0, csr(3'b001, ADDR) ^ 32'h4, 0);
        step("R12", 1'b0, 1'b0, 1'b0, csr(3'b001, ADDR), 0);
        step("R10", 1'b1, 1'b1, 1'b0, csr(3'b001, ADDR), 0);
        step("R7",  1'b1, 1'b0, 1'b0, csr(3'b001, ADDR), 0);
        step("R10", 1'b1, 1'b1, 1'b0, csr(3'b011, ADDR), B6);

        // mixed stream checked against the model every cycle
        for (int i = 0; i < 2000; i++) begin
            int          k;
            logic [31:0] w;
            k = $urandom_range(0, 9);
            case (k)
                0, 1:    w = ERET;
                2, 3, 4: w = csr(3'($urandom_range(0, 7)), ADDR);
                5:       w = csr(3'($urandom_range(0, 7)), ADDR ^ 12'h010);
                default: w = NOP;
            endcase
            step("R10", 1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 2) == 0),
                 1'($urandom_range(0, 7) == 0), w, $urandom);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule